// File: doc/BRIEF.md
# FSK Zero-Crossing Tone Discriminator

This block turns a squared cassette audio signal into a tone-level signal. It takes the one-bit output of a comparator that squares the audio around a mid-rail bias. It measures the time between successive zero crossings on a 1 MHz tick enable, in microseconds. It then judges every half-cycle on its own as the high tone (about 138 us per half-cycle) or the low tone (about 207 us). No phase-locked loop is used. Because each half-period is decided separately, the output follows accelerated recordings whose sub-bit slots hold a fractional number of tone cycles.

The tone output is high while the high tone is heard and low while the low tone is heard. A measured half-period is split at a threshold between the two nominal values. It must also fall inside a tolerance window around one of the two tones, or it is ignored. Two flags report the state of the input. One says that zero crossings are arriving at all. The other says that the crossings have the spacing of a proper tone stream. Speech or noise therefore shows as present but not valid. A quiet line clears both flags.

The comparator input is re-timed by two flip-flops. Pulses shorter than a deglitch time are discarded, and every accepted edge of either polarity counts as a zero crossing.

Top module: `fsk_tone_disc`

## Requirements
- R1: After reset, tone_o, present_o and valid_o are all 0.
- R2: A half-period of 110 to 160 ticks (both limits included, below the 173-tick split) drives tone_o to 1.
- R3: A half-period of 180 to 240 ticks (both limits included) drives tone_o to 0.
- R4: A half-period outside both windows (for example 109, 170, 241 ticks, or the first crossing after silence) leaves tone_o unchanged.
- R5: Each in-window half-period takes effect on its own, so alternating 138 and 207 tick half-periods toggle tone_o every half-cycle.
- R6: Rising and falling edges of cmp_i both count as zero crossings. A cmp_i pulse shorter than 20 ticks is ignored and does not split the current half-period.
- R7: present_o sets on the first accepted zero crossing, whether or not the intervals are in a window.
- R8: valid_o sets once 8 consecutive half-periods fall in a window. It stays 0 after only 7.
- R9: valid_o clears after 4 consecutive out-of-window half-periods. It stays 1 after only 3.
- R10: 1000 ticks without an accepted crossing clear present_o and valid_o, while tone_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 1 MHz; one tick is one microsecond |
| cmp_i | input | 1 | Asynchronous comparator output (audio squared around bias) |
| tone_o | output | 1 | 1 while the high tone is detected, 0 while the low tone is detected |
| present_o | output | 1 | Zero crossings are being received |
| valid_o | output | 1 | Crossing spacing matches the two tones |

## Verification
On every cycle, the assertions check four things. tone_o changes only right after a measurement. A silent line clears both flags on the next cycle. valid_o never stands without present_o. Each flag rises only from a measurement, and an accepted edge lasts exactly one cycle. The exact window limits, the threshold between the tones, the counts of 8 and 4 consecutive half-periods, the rejection of short pulses and the 1000-tick timeout depend on the stimulus timing. Only the bench scenarios can show these, by driving crossing patterns with known spacing and reading the outputs after each one.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    CLS_HI  = 2'd0,
    CLS_LO  = 2'd1,
    CLS_BAD = 2'd2
  } tone_cls_e;
endpackage

// File: rtl/fsk_edge_filter.sv
module fsk_edge_filter #(
  parameter int DEGLITCH = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmp_i,
  output logic edge_o
);
  localparam int DG_W = $clog2(DEGLITCH + 1);
  localparam logic [DG_W-1:0] DG_LAST = DG_W'(DEGLITCH - 1);

  logic [1:0]      sync_q;
  logic            level_q;
  logic [DG_W-1:0] dg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      dg_q    <= '0;
      edge_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], cmp_i};
      edge_o <= 1'b0;
      if (sync_q[1] == level_q) begin
        dg_q <= '0;
      end else if (tick_i) begin
        // new level must hold for DEGLITCH ticks
        if (dg_q == DG_LAST) begin
          level_q <= sync_q[1];
          dg_q    <= '0;
          edge_o  <= 1'b1;
        end else begin
          dg_q <= dg_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_interval_timer.sv
module fsk_interval_timer #(
  parameter int TIMEOUT = 1000,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             idle_o
);
  localparam logic [CNT_W-1:0] T_MAX = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= T_MAX;  // start idle: first crossing measures as too long
      meas_vld_o <= 1'b0;
      meas_o     <= '0;
    end else begin
      meas_vld_o <= 1'b0;
      if (edge_i) begin
        meas_o     <= cnt_q;
        meas_vld_o <= 1'b1;
        cnt_q      <= '0;
      end else if (tick_i && cnt_q != T_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idle_o = (cnt_q == T_MAX);
endmodule

// File: rtl/fsk_classifier.sv
module fsk_classifier
  import fsk_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int HI_MIN = 110,
  parameter int HI_MAX = 160,
  parameter int LO_MIN = 180,
  parameter int LO_MAX = 240,
  parameter int SPLIT  = 173
) (
  input  logic [CNT_W-1:0] meas_i,
  output tone_cls_e        cls_o
);
  localparam logic [CNT_W-1:0] HI_A = CNT_W'(HI_MIN);
  localparam logic [CNT_W-1:0] HI_B = CNT_W'(HI_MAX);
  localparam logic [CNT_W-1:0] LO_A = CNT_W'(LO_MIN);
  localparam logic [CNT_W-1:0] LO_B = CNT_W'(LO_MAX);
  localparam logic [CNT_W-1:0] SPL  = CNT_W'(SPLIT);

  logic is_short, in_hi, in_lo;

  always_comb begin
    is_short = meas_i < SPL;
    in_hi    = is_short  && meas_i >= HI_A && meas_i <= HI_B;
    in_lo    = !is_short && meas_i >= LO_A && meas_i <= LO_B;
    if (in_hi)      cls_o = CLS_HI;
    else if (in_lo) cls_o = CLS_LO;
    else            cls_o = CLS_BAD;
  end
endmodule

// File: rtl/fsk_lock_tracker.sv
module fsk_lock_tracker
  import fsk_pkg::*;
#(
  parameter int SET_N = 8,
  parameter int CLR_N = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      meas_vld_i,
  input  tone_cls_e cls_i,
  input  logic      idle_i,
  output logic      tone_o,
  output logic      present_o,
  output logic      valid_o
);
  localparam int GW = $clog2(SET_N + 1);
  localparam int BW = $clog2(CLR_N + 1);
  localparam logic [GW-1:0] G_MAX = GW'(SET_N);
  localparam logic [GW-1:0] G_M1  = GW'(SET_N - 1);
  localparam logic [BW-1:0] B_MAX = BW'(CLR_N);
  localparam logic [BW-1:0] B_M1  = BW'(CLR_N - 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tone_o    <= 1'b0;
      present_o <= 1'b0;
      valid_o   <= 1'b0;
      good_q    <= '0;
      bad_q     <= '0;
    end else if (idle_i) begin
      present_o <= 1'b0;
      valid_o   <= 1'b0;
      good_q    <= '0;
      bad_q     <= '0;
    end else if (meas_vld_i) begin
      present_o <= 1'b1;
      if (cls_i == CLS_BAD) begin
        good_q <= '0;
        if (bad_q != B_MAX) bad_q <= bad_q + 1'b1;
        if (bad_q >= B_M1)  valid_o <= 1'b0;
      end else begin
        tone_o <= (cls_i == CLS_HI);
        bad_q  <= '0;
        if (good_q != G_MAX) good_q <= good_q + 1'b1;
        if (good_q >= G_M1)  valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_tone_disc.sv
module fsk_tone_disc
  import fsk_pkg::*;
#(
  parameter int DEGLITCH = 20,
  parameter int TIMEOUT  = 1000,
  parameter int HI_MIN   = 110,
  parameter int HI_MAX   = 160,
  parameter int LO_MIN   = 180,
  parameter int LO_MAX   = 240,
  parameter int SPLIT    = 173,
  parameter int SET_N    = 8,
  parameter int CLR_N    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmp_i,
  output logic tone_o,
  output logic present_o,
  output logic valid_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             edge_w;
  logic             meas_vld_w;
  logic [CNT_W-1:0] meas_w;
  logic             idle_w;
  tone_cls_e        cls_w;

  fsk_edge_filter #(.DEGLITCH(DEGLITCH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cmp_i  (cmp_i),
    .edge_o (edge_w)
  );

  fsk_interval_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .edge_i     (edge_w),
    .meas_vld_o (meas_vld_w),
    .meas_o     (meas_w),
    .idle_o     (idle_w)
  );

  fsk_classifier #(
    .CNT_W(CNT_W), .HI_MIN(HI_MIN), .HI_MAX(HI_MAX),
    .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .SPLIT(SPLIT)
  ) u_cls (
    .meas_i (meas_w),
    .cls_o  (cls_w)
  );

  fsk_lock_tracker #(.SET_N(SET_N), .CLR_N(CLR_N)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld_w),
    .cls_i      (cls_w),
    .idle_i     (idle_w),
    .tone_o     (tone_o),
    .present_o  (present_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/fsk_tone_disc_chk.sv
module fsk_tone_disc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic edge_i,
  input logic meas_vld_i,
  input logic idle_i,
  input logic tone_i,
  input logic present_i,
  input logic valid_i
);
  p_tone_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld_i |=> $stable(tone_i));

  p_edge_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !edge_i);

  p_present_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_i) |-> $past(meas_vld_i));

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(meas_vld_i));

  p_valid_in_present_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> present_i);

  p_idle_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (!present_i && !valid_i));
endmodule

bind fsk_tone_disc fsk_tone_disc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .edge_i     (edge_w),
  .meas_vld_i (meas_vld_w),
  .idle_i     (idle_w),
  .tone_i     (tone_o),
  .present_i  (present_o),
  .valid_i    (valid_o)
);

// File: tb/fsk_tone_disc_tb.sv
module fsk_tone_disc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmp = 1'b0;
  logic tone, present, valid;
  int   n_chk = 0;
  int   n_err = 0;
  int   tdiv = 0;

  fsk_tone_disc u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .cmp_i     (cmp),
    .tone_o    (tone),
    .present_o (present),
    .valid_o   (valid)
  );

  always #2ns clk = ~clk;

  // 1 us tick = every 4th clock, changed at negedge
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    @(negedge clk);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // toggle comparator, then hold for us ticks
  task automatic send(input int us);
    cmp = ~cmp;
    wait_ticks(us);
  endtask

  task automatic t_reset();
    chk("R1 tone", tone, 1'b0);
    chk("R1 present", present, 1'b0);
    chk("R1 valid", valid, 1'b0);
  endtask

  task automatic t_hi_lock();
    for (int i = 0; i < 8; i++) send(138);
    chk("R8 seven in-window", valid, 1'b0);
    chk("R7 present", present, 1'b1);
    chk("R2 high tone", tone, 1'b1);
    send(138);
    chk("R8 eighth in-window", valid, 1'b1);
  endtask

  task automatic t_low();
    send(207);
    chk("R2 still high", tone, 1'b1);
    send(207);
    chk("R3 low tone", tone, 1'b0);
    chk("R8 valid kept", valid, 1'b1);
  endtask

  task automatic t_alternate();
    int prev = 207;
    for (int i = 0; i < 6; i++) begin
      int us = (i % 2 == 0) ? 138 : 207;
      send(us);
      chk("R5 per half-period", tone, (prev == 138));
      prev = us;
    end
  endtask

  task automatic t_bounds();
    send(160);
    chk("R3 207", tone, 1'b0);
    send(180);
    chk("R2 upper limit 160", tone, 1'b1);
    send(109);
    chk("R3 lower limit 180", tone, 1'b0);
    send(241);
    chk("R4 109 ignored", tone, 1'b0);
    send(110);
    chk("R4 241 ignored", tone, 1'b0);
    send(240);
    chk("R2 lower limit 110", tone, 1'b1);
    send(207);
    chk("R3 upper limit 240", tone, 1'b0);
    chk("R9 two bad keep valid", valid, 1'b1);
  endtask

  task automatic t_glitch();
    cmp = ~cmp;
    wait_ticks(60);
    cmp = ~cmp;          // 10-tick pulse, below deglitch time
    wait_ticks(10);
    cmp = ~cmp;
    wait_ticks(68);
    chk("R6 prior low", tone, 1'b0);
    send(207);
    chk("R6 glitch rejected", tone, 1'b1);
    chk("R6 valid kept", valid, 1'b1);
  endtask

  task automatic t_invalid();
    send(170);
    chk("R3 207 before invalid", tone, 1'b0);
    for (int i = 0; i < 3; i++) send(170);
    chk("R9 three bad", valid, 1'b1);
    chk("R4 170 ignored", tone, 1'b0);
    send(170);
    chk("R9 four bad", valid, 1'b0);
    chk("R7 present on invalid", present, 1'b1);
  endtask

  task automatic t_timeout();
    send(138);
    send(138);
    chk("R2 high before silence", tone, 1'b1);
    wait_ticks(872 - 1);
    chk("R10 before timeout", present, 1'b1);
    wait_ticks(20);
    chk("R10 present cleared", present, 1'b0);
    chk("R10 valid cleared", valid, 1'b0);
    chk("R10 tone held", tone, 1'b1);
  endtask

  task automatic t_present_invalid();
    send(300);
    chk("R7 present after silence", present, 1'b1);
    chk("R4 first crossing ignored", tone, 1'b1);
    send(300);
    chk("R7 still not valid", valid, 1'b0);
    chk("R4 300 ignored", tone, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_hi_lock();
    t_low();
    t_alternate();
    t_bounds();
    t_glitch();
    t_invalid();
    t_timeout();
    t_present_invalid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got running expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule